// File: doc/BRIEF.md
# Bit-Sliced Accumulator Logic Unit

This block is a 16-bit accumulator register made of identical one-bit slices. Each slice stores its accumulator bit in a JK flip-flop. A small gate network in the slice picks the bit's next value from one of seven operations: AND with the data word, add the data word, copy the data word, copy the byte-wide input word, invert, shift toward the least significant bit, or shift toward the most significant bit. The adders of all slices form a ripple-carry chain. The carry into slice 0 comes from an external pin. The carry out of the top slice goes into a one-bit extend register.

An external sequencer raises exactly one operation line and pulses the load line. The accumulator and the extend bit change on the next clock edge. Only the lower eight slices connect to the input word, so loading the input word clears the upper byte. The extend bit closes the shift path: it supplies the bit that enters the shifted word, and it keeps the bit that leaves it.

Top module: `acc_slice_unit`

## Requirements
- R1: While reset is asserted, the accumulator reads 0x0000 and the extend bit reads 0.
- R2: When load_en is 0, the accumulator and the extend bit keep their values, whatever the operation lines and data inputs are.
- R3: With load_en=1 and op_and=1, the accumulator becomes the bitwise AND of its old value and dr_in. The extend bit is unchanged.
- R4: With load_en=1 and op_add=1, {ext_out, acc_out} becomes the 17-bit sum old acc_out + dr_in + carry_in. Bit 16 of that sum is the carry out of bit 15.
- R5: With load_en=1 and op_xfer=1, the accumulator becomes dr_in. The extend bit is unchanged.
- R6: With load_en=1 and op_inp=1, accumulator bits 7..0 take inp_in and bits 15..8 become 0. The extend bit is unchanged.
- R7: With load_en=1 and op_cpl=1, every accumulator bit is inverted. The extend bit is unchanged.
- R8: With load_en=1 and op_shr=1, bit i takes old bit i+1 for i < 15 and bit 15 takes the old extend bit. The extend bit takes old bit 0.
- R9: With load_en=1 and op_shl=1, bit i takes old bit i-1 for i > 0 and bit 0 takes the old extend bit. The extend bit takes old bit 15.
- R10: With load_en=1 and no operation line raised, the accumulator becomes 0x0000 and the extend bit is unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| load_en | input | 1 | Write enable for every slice flip-flop and the extend bit |
| op_and | input | 1 | Select AND with dr_in |
| op_add | input | 1 | Select add of dr_in and carry_in |
| op_xfer | input | 1 | Select copy of dr_in |
| op_inp | input | 1 | Select copy of inp_in into the low byte |
| op_cpl | input | 1 | Select bitwise inversion |
| op_shr | input | 1 | Select shift toward bit 0 through the extend bit |
| op_shl | input | 1 | Select shift toward bit 15 through the extend bit |
| carry_in | input | 1 | Carry into slice 0 of the adder chain |
| dr_in | input | 16 | Data word operand |
| inp_in | input | 8 | Byte-wide input word |
| acc_out | output | 16 | Accumulator value |
| ext_out | output | 1 | Extend bit |

## Verification
One chained sequence walks the accumulator through every operation. Each step starts from the state the previous step left. The add vectors include a carry that ripples across all sixteen slices into the extend bit, and a carry_in that enters slice 0 alone. Together these show whether the chain is complete and whether the carry pin is wired to slice 0. The shift steps are ordered so that the extend bit holds 1 at some steps and 0 at others, and so that a 1 sits at each end of the word. This shows whether the serial input and the captured bit each come from the correct end. The input-word transfer uses a data word of all ones and an extend bit of 1, so a fault that feeds the upper byte or disturbs the extend bit appears in the result.

// File: rtl/acc_pkg.sv
package acc_pkg;

  localparam int ACC_W  = 16;
  localparam int INP_W  = 8;
  localparam int OP_CNT = 7;

  // One field per operation line; at most one is expected high.
  typedef struct packed {
    logic f_and;
    logic f_add;
    logic f_xfer;
    logic f_inp;
    logic f_cpl;
    logic f_shr;
    logic f_shl;
  } op_sel_t;

endpackage

// File: rtl/acc_bit_stage.sv
// Combinational part of one slice: full adder and operation selection.
module acc_bit_stage
  import acc_pkg::*;
(
  input  op_sel_t ops,
  input  logic    acc_self,
  input  logic    acc_up,
  input  logic    acc_dn,
  input  logic    dr_bit,
  input  logic    inp_bit,
  input  logic    c_in,
  output logic    c_out,
  output logic    sel_bit
);

  logic sum_bit;
  logic [OP_CNT-1:0] terms;

  always_comb begin
    sum_bit = acc_self ^ dr_bit ^ c_in;
    c_out   = (acc_self & dr_bit) | (c_in & (acc_self ^ dr_bit));
  end

  always_comb begin
    terms[0] = ops.f_and  & acc_self & dr_bit;
    terms[1] = ops.f_add  & sum_bit;
    terms[2] = ops.f_xfer & dr_bit;
    terms[3] = ops.f_inp  & inp_bit;
    terms[4] = ops.f_cpl  & ~acc_self;
    terms[5] = ops.f_shr  & acc_up;
    terms[6] = ops.f_shl  & acc_dn;
    sel_bit  = |terms;
  end

endmodule

// File: rtl/acc_jk_cell.sv
// JK storage cell; J/K derived from the selected bit under load.
module acc_jk_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic ld,
  input  logic d,
  output logic q
);

  logic j_in, k_in, q_nxt;

  always_comb begin
    j_in  = ld & d;
    k_in  = ld & ~d;
    q_nxt = (j_in & ~q) | (~k_in & q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= 1'b0;
    else        q <= q_nxt;
  end

endmodule

// File: rtl/acc_ext_ctrl.sv
// Extend bit: end carry on add, exiting bit on shifts, hold otherwise.
module acc_ext_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic ld,
  input  logic sel_add,
  input  logic sel_shr,
  input  logic sel_shl,
  input  logic carry_top,
  input  logic acc_lsb,
  input  logic acc_msb,
  output logic e_q
);

  logic e_en, e_nxt;

  always_comb begin
    e_en  = ld & (sel_add | sel_shr | sel_shl);
    e_nxt = e_q;
    if (e_en) begin
      if (sel_add)      e_nxt = carry_top;
      else if (sel_shr) e_nxt = acc_lsb;
      else              e_nxt = acc_msb;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) e_q <= 1'b0;
    else        e_q <= e_nxt;
  end

endmodule

// File: rtl/acc_slice_unit.sv
module acc_slice_unit
  import acc_pkg::*;
#(
  parameter int W     = ACC_W,
  parameter int IN_W  = INP_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_en,
  input  logic         op_and,
  input  logic         op_add,
  input  logic         op_xfer,
  input  logic         op_inp,
  input  logic         op_cpl,
  input  logic         op_shr,
  input  logic         op_shl,
  input  logic         carry_in,
  input  logic [W-1:0] dr_in,
  input  logic [IN_W-1:0] inp_in,
  output logic [W-1:0] acc_out,
  output logic         ext_out
);

  localparam int TOP = W - 1;

  // Reset: asserted asynchronously, released on the clock.
  logic [1:0] rst_pipe;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  op_sel_t          ops;
  logic [W:0]       carry;
  logic [W-1:0]     sel;
  logic [W-1:0]     inp_w;
  logic [W-1:0]     acc_q;
  logic             e_q;

  always_comb begin
    ops = '{f_and: op_and, f_add: op_add, f_xfer: op_xfer, f_inp: op_inp,
            f_cpl: op_cpl, f_shr: op_shr, f_shl: op_shl};
  end

  assign carry[0] = carry_in;

  for (genvar i = 0; i < W; i++) begin : g_slice
    logic up_nb, dn_nb;

    if (i < IN_W) begin : g_inp
      assign inp_w[i] = inp_in[i];
    end else begin : g_noinp
      assign inp_w[i] = 1'b0;
    end

    if (i == TOP) begin : g_up_end
      assign up_nb = e_q;
    end else begin : g_up_mid
      assign up_nb = acc_q[i+1];
    end

    if (i == 0) begin : g_dn_end
      assign dn_nb = e_q;
    end else begin : g_dn_mid
      assign dn_nb = acc_q[i-1];
    end

    acc_bit_stage u_stage (
      .ops      (ops),
      .acc_self (acc_q[i]),
      .acc_up   (up_nb),
      .acc_dn   (dn_nb),
      .dr_bit   (dr_in[i]),
      .inp_bit  (inp_w[i]),
      .c_in     (carry[i]),
      .c_out    (carry[i+1]),
      .sel_bit  (sel[i])
    );

    acc_jk_cell u_cell (
      .clk   (clk),
      .rst_n (rst_sync_n),
      .ld    (load_en),
      .d     (sel[i]),
      .q     (acc_q[i])
    );
  end

  acc_ext_ctrl u_ext (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .ld        (load_en),
    .sel_add   (op_add),
    .sel_shr   (op_shr),
    .sel_shl   (op_shl),
    .carry_top (carry[W]),
    .acc_lsb   (acc_q[0]),
    .acc_msb   (acc_q[TOP]),
    .e_q       (e_q)
  );

  assign acc_out = acc_q;
  assign ext_out = e_q;

endmodule

// File: rtl/acc_slice_unit_chk.sv
module acc_slice_unit_chk #(
  parameter int W    = 16,
  parameter int IN_W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         load_en,
  input logic         op_and,
  input logic         op_add,
  input logic         op_xfer,
  input logic         op_inp,
  input logic         op_cpl,
  input logic         op_shr,
  input logic         op_shl,
  input logic         carry_in,
  input logic [W-1:0] dr_in,
  input logic [IN_W-1:0] inp_in,
  input logic [W-1:0] acc_out,
  input logic         ext_out
);

  logic no_op;
  assign no_op = !(op_and | op_add | op_xfer | op_inp | op_cpl | op_shr | op_shl);

  // R1: cleared while in reset
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      a_r1_reset_clear: assert (acc_out == '0 && ext_out == 1'b0);
    end
  end

  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !load_en |=> ($stable(acc_out) && $stable(ext_out)));

  a_r3_and: assert property (@(posedge clk) disable iff (!rst_n)
    (load_en && op_and) |=> (acc_out == ($past(acc_out) & $past(dr_in)) && $stable(ext_out)));

  a_r4_add: assert property (@(posedge clk) disable iff (!rst_n)
    (load_en && op_add) |=> ({ext_out, acc_out} ==
      ({1'b0, $past(acc_out)} + {1'b0, $past(dr_in)} + {{W{1'b0}}, $past(carry_in)})));

  a_r5_xfer: assert property (@(posedge clk) disable iff (!rst_n)
    (load_en && op_xfer) |=> (acc_out == $past(dr_in) && $stable(ext_out)));

  a_r6_inp: assert property (@(posedge clk) disable iff (!rst_n)
    (load_en && op_inp) |=> (acc_out == {{(W-IN_W){1'b0}}, $past(inp_in)} && $stable(ext_out)));

  a_r7_cpl: assert property (@(posedge clk) disable iff (!rst_n)
    (load_en && op_cpl) |=> (acc_out == ~$past(acc_out) && $stable(ext_out)));

  a_r8_shr: assert property (@(posedge clk) disable iff (!rst_n)
    (load_en && op_shr) |=> ({acc_out, ext_out} == {$past(ext_out), $past(acc_out)}));

  a_r9_shl: assert property (@(posedge clk) disable iff (!rst_n)
    (load_en && op_shl) |=> ({ext_out, acc_out} == {$past(acc_out), $past(ext_out)}));

  a_r10_none: assert property (@(posedge clk) disable iff (!rst_n)
    (load_en && no_op) |=> (acc_out == '0 && $stable(ext_out)));

endmodule

bind acc_slice_unit acc_slice_unit_chk #(.W(W), .IN_W(IN_W)) chk_i (
  .clk      (clk),
  .rst_n    (rst_sync_n),
  .load_en  (load_en),
  .op_and   (op_and),
  .op_add   (op_add),
  .op_xfer  (op_xfer),
  .op_inp   (op_inp),
  .op_cpl   (op_cpl),
  .op_shr   (op_shr),
  .op_shl   (op_shl),
  .carry_in (carry_in),
  .dr_in    (dr_in),
  .inp_in   (inp_in),
  .acc_out  (acc_out),
  .ext_out  (ext_out)
);

// File: tb/acc_slice_unit_tb_top.sv
module acc_slice_unit_tb_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        load_en;
  logic        op_and, op_add, op_xfer, op_inp, op_cpl, op_shr, op_shl;
  logic        carry_in;
  logic [15:0] dr_in;
  logic [7:0]  inp_in;
  logic [15:0] acc_out;
  logic        ext_out;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  acc_slice_unit dut_i (
    .clk(clk), .rst_n(rst_n), .load_en(load_en),
    .op_and(op_and), .op_add(op_add), .op_xfer(op_xfer), .op_inp(op_inp),
    .op_cpl(op_cpl), .op_shr(op_shr), .op_shl(op_shl),
    .carry_in(carry_in), .dr_in(dr_in), .inp_in(inp_in),
    .acc_out(acc_out), .ext_out(ext_out)
  );

  // op codes: 0 none, 1 and, 2 add, 3 xfer, 4 inp, 5 cpl, 6 shr, 7 shl
  typedef struct packed {
    logic        ld;
    logic [2:0]  op;
    logic        cin;
    logic [15:0] dr;
    logic [7:0]  inp;
    logic [15:0] exp_acc;
    logic        exp_e;
  } vec_t;

  localparam int NV = 18;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 3'd3, 1'b0, 16'h5875, 8'h00, 16'h5875, 1'b0}, // R5
    '{1'b1, 3'd1, 1'b0, 16'h2ABC, 8'h00, 16'h0834, 1'b0}, // R3
    '{1'b1, 3'd2, 1'b0, 16'hF7CC, 8'h00, 16'h0000, 1'b1}, // R4 full ripple
    '{1'b1, 3'd6, 1'b0, 16'h0000, 8'h00, 16'h8000, 1'b0}, // R8 E enters bit 15
    '{1'b1, 3'd7, 1'b0, 16'h0000, 8'h00, 16'h0000, 1'b1}, // R9 bit 15 into E
    '{1'b1, 3'd2, 1'b1, 16'h1234, 8'h00, 16'h1235, 1'b0}, // R4 carry_in
    '{1'b1, 3'd5, 1'b0, 16'h0000, 8'h00, 16'hEDCA, 1'b0}, // R7
    '{1'b1, 3'd4, 1'b0, 16'hFFFF, 8'hA5, 16'h00A5, 1'b0}, // R6
    '{1'b0, 3'd2, 1'b1, 16'hFFFF, 8'hFF, 16'h00A5, 1'b0}, // R2 no load
    '{1'b1, 3'd7, 1'b0, 16'h0000, 8'h00, 16'h014A, 1'b0}, // R9
    '{1'b1, 3'd5, 1'b0, 16'h0000, 8'h00, 16'hFEB5, 1'b0}, // R7
    '{1'b1, 3'd7, 1'b0, 16'h0000, 8'h00, 16'hFD6A, 1'b1}, // R9 bit 15 into E
    '{1'b1, 3'd6, 1'b0, 16'h0000, 8'h00, 16'hFEB5, 1'b0}, // R8 E=1 enters bit 15
    '{1'b1, 3'd0, 1'b0, 16'hFFFF, 8'hFF, 16'h0000, 1'b0}, // R10
    '{1'b1, 3'd2, 1'b1, 16'hFFFF, 8'h00, 16'h0000, 1'b1}, // R4 carry_in ripples out
    '{1'b1, 3'd3, 1'b0, 16'hABCD, 8'h00, 16'hABCD, 1'b1}, // R5 E held
    '{1'b1, 3'd4, 1'b0, 16'hFFFF, 8'h3C, 16'h003C, 1'b1}, // R6 upper byte 0
    '{1'b1, 3'd0, 1'b1, 16'h1111, 8'h11, 16'h0000, 1'b1}  // R10 E held
  };

  function automatic string req_of(input logic ld, input logic [2:0] op);
    if (!ld) return "R2";
    case (op)
      3'd1: return "R3";
      3'd2: return "R4";
      3'd3: return "R5";
      3'd4: return "R6";
      3'd5: return "R7";
      3'd6: return "R8";
      3'd7: return "R9";
      default: return "R10";
    endcase
  endfunction

  task automatic check(input string req, input logic [15:0] ea, input logic ee);
    checks++;
    if (acc_out !== ea || ext_out !== ee) begin
      fails++;
      $display("FAIL %s acc=%h e=%b expected acc=%h e=%b", req, acc_out, ext_out, ea, ee);
    end
  endtask

  task automatic drive(input vec_t v);
    load_en  = v.ld;
    op_and   = (v.op == 3'd1);
    op_add   = (v.op == 3'd2);
    op_xfer  = (v.op == 3'd3);
    op_inp   = (v.op == 3'd4);
    op_cpl   = (v.op == 3'd5);
    op_shr   = (v.op == 3'd6);
    op_shl   = (v.op == 3'd7);
    carry_in = v.cin;
    dr_in    = v.dr;
    inp_in   = v.inp;
  endtask

  initial begin
    rst_n = 1'b0;
    drive('0);
    repeat (3) @(negedge clk);
    check("R1", 16'h0000, 1'b0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    for (int n = 0; n < NV; n++) begin
      drive(VECS[n]);
      @(negedge clk);
      check(req_of(VECS[n].ld, VECS[n].op), VECS[n].exp_acc, VECS[n].exp_e);
    end
    drive('0);

    // R1: reset mid-run clears a non-zero state at once
    #2 rst_n = 1'b0;
    #1 check("R1", 16'h0000, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule